// File: doc/BRIEF.md
# CPU Injection Word Framer

This block turns a frame from the host processor into the sequence of 32-bit writes that a switch CPU injection queue expects. A request gives the frame length in bytes and a per-port internal header of a fixed number of words. The frame bytes follow on a separate byte stream. The block first checks that the queue is ready. If it is not, it rejects the request and raises a busy pulse. If it is, it emits the following writes in order: a start control word, the header words, the packed data words, zero padding up to the minimum frame size, an end control word carrying the valid-byte count, and a dummy FCS word.

Each write leaves on a valid/ready port as a 32-bit word with a flag that marks it as a control word. After the FCS word is taken, the block samples the queue's watermark flag. If the flag is set, the block refuses new frames for a hold-off time derived from the clock frequency. At the end of that time it pulses a clear of the watermark counter, but only if the flag is still set. It then accepts frames again. Counters record accepted frames, accepted bytes and rejected requests.

Top module: `inj_framer`

## Requirements
- R1: A request presented while `q_rdy_i` is low is consumed without any write. `busy_o` is high for exactly the next cycle, `drops_o` rises by one, and `frames_o` and `bytes_o` do not change.
- R2: An accepted frame starts with a control write (`wr_ctrl_o`=1) of value 0x11. Bit 0 is the start flag and bits [7:4] hold a gap size of 1.
- R3: The HDR_WORDS header words follow with `wr_ctrl_o`=0. Word k is taken from `req_hdr_i[32k+31:32k]`, in increasing k.
- R4: Next come ceil(len/4) data words. Frame byte i sits in bits [8(i mod 4)+7 : 8(i mod 4)] of data word i/4, and unused bytes of the last word are zero.
- R5: All-zero words are then added until 15 data words in total (60 bytes) have been written. A zero-length frame therefore gives 15 zero words.
- R6: The end control write (`wr_ctrl_o`=1) has bit 1 set, gap size 1 in bits [7:4], and a valid-byte field in bits [3:2]. That field is 0 when len < 60 and len mod 4 otherwise.
- R7: The last write of a frame is an all-zero FCS word with `wr_ctrl_o`=0.
- R8: If `wm_hit_i` is high in the cycle the FCS word is taken, `req_ready_o` stays low for 6250 cycles (50 us at 125 MHz). Otherwise the block is ready again in the next cycle.
- R9: When the hold-off ends, `wm_clr_o` pulses for one cycle if `wm_hit_i` is still high in that cycle, and stays low otherwise.
- R10: On every accepted request, `frames_o` rises by one and `bytes_o` rises by the requested length.
- R11: While `wr_valid_o` is high and `wr_ready_i` is low, the write word and its control flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Frame request valid |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_len_i | input | LEN_W | Frame length in bytes |
| req_hdr_i | input | 32*HDR_WORDS | Internal header, word 0 in the low bits |
| q_rdy_i | input | 1 | Injection queue ready flag |
| busy_o | output | 1 | One-cycle pulse on a rejected request |
| byte_valid_i | input | 1 | Frame byte valid |
| byte_ready_o | output | 1 | Frame byte accepted |
| byte_i | input | 8 | Frame byte |
| wr_valid_o | output | 1 | Queue write valid |
| wr_ready_i | input | 1 | Queue write accepted |
| wr_word_o | output | 32 | Queue write word |
| wr_ctrl_o | output | 1 | Write is a control word |
| wm_hit_i | input | 1 | Watermark-reached flag |
| wm_clr_o | output | 1 | Watermark counter clear pulse |
| frames_o | output | CNT_W | Accepted frame count |
| bytes_o | output | CNT_W | Accepted byte count |
| drops_o | output | CNT_W | Rejected request count |

## Verification
Two events can fall in the same cycle: the FCS word being taken under backpressure, and the watermark flag being sampled. The bench raises the watermark before the frame and then throttles `wr_ready_i` with a pseudo-random pattern, so the FCS handshake lands in an arbitrary cycle. It judges the result by the exact distance from that handshake to the first cycle `req_ready_o` is high again. A second overlap is a byte being gathered in the same cycle a finished word is stalled. Its result is judged by the scoreboard order and by the stability of the stalled word.

// File: rtl/inj_pkg.sv
package inj_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SOF,
        S_HDR,
        S_DATA,
        S_PAD,
        S_EOF,
        S_FCS,
        S_HOLD
    } inj_state_e;

    localparam int CTRL_SOF_BIT = 0;
    localparam int CTRL_EOF_BIT = 1;
    localparam int CTRL_VLD_LSB = 2;
    localparam int CTRL_GAP_LSB = 4;
    localparam logic [3:0] CTRL_GAP = 4'd1;

    function automatic logic [31:0] ctrl_word(input logic sof, input logic eof,
                                              input logic [1:0] vld);
        logic [31:0] w;
        w = '0;
        w[CTRL_SOF_BIT] = sof;
        w[CTRL_EOF_BIT] = eof;
        w[CTRL_VLD_LSB +: 2] = vld;
        w[CTRL_GAP_LSB +: 4] = CTRL_GAP;
        return w;
    endfunction

endpackage

// File: rtl/inj_byte_packer.sv
module inj_byte_packer #(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    input  logic [7:0]       byte_i,
    output logic             word_valid_o,
    output logic [31:0]      word_o,
    output logic             last_o,
    input  logic             take_i
);

    typedef struct packed {
        logic [LEN_W-1:0] left;
        logic [1:0]       lane;
        logic [31:0]      acc;
        logic             full;
    } pk_t;

    pk_t q, d;

    always_comb begin
        d = q;
        byte_ready_o = !q.full && (q.left != '0);
        if (load_i) begin
            d.left = len_i;
            d.lane = '0;
            d.acc  = '0;
            d.full = 1'b0;
        end else begin
            if (take_i) begin
                d.full = 1'b0;
                d.acc  = '0;
            end
            if (byte_valid_i && byte_ready_o) begin
                d.acc[8*q.lane +: 8] = byte_i;
                d.left = q.left - 1'b1;
                if (q.lane == 2'd3 || q.left == LEN_W'(1)) begin
                    d.full = 1'b1;
                    d.lane = '0;
                end else begin
                    d.lane = q.lane + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_valid_o = q.full;
    assign word_o       = q.acc;
    assign last_o       = (q.left == '0);

    AST_PACK_WORD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !take_i && !load_i) |=> (word_valid_o && $stable(word_o))); // R4

endmodule

// File: rtl/inj_holdoff_timer.sv
module inj_holdoff_timer #(
    parameter int CYCLES = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o,
    output logic expire_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);
    assign expire_o = (cnt_q == CW'(1));

    AST_TIMER_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !active_o); // R8

endmodule

// File: rtl/inj_tx_counters.sv
module inj_tx_counters #(
    parameter int LEN_W = 14,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             rej_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] frames_o,
    output logic [CNT_W-1:0] bytes_o,
    output logic [CNT_W-1:0] drops_o
);

    typedef struct packed {
        logic [CNT_W-1:0] frames;
        logic [CNT_W-1:0] bytes;
        logic [CNT_W-1:0] drops;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d = q;
        if (acc_i) begin
            d.frames = q.frames + 1'b1;
            d.bytes  = q.bytes + CNT_W'(len_i);
        end
        if (rej_i) d.drops = q.drops + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frames_o = q.frames;
    assign bytes_o  = q.bytes;
    assign drops_o  = q.drops;

    AST_CNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_i && rej_i)); // R10

endmodule

// File: rtl/inj_framer.sv
module inj_framer
    import inj_pkg::*;
#(
    parameter int HDR_WORDS = 4,
    parameter int LEN_W     = 14,
    parameter int CNT_W     = 32,
    parameter int MIN_BYTES = 60,
    parameter int CLK_HZ    = 125_000_000,
    parameter int HOLD_NS   = 50_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic [LEN_W-1:0]       req_len_i,
    input  logic [32*HDR_WORDS-1:0] req_hdr_i,
    input  logic                   q_rdy_i,
    output logic                   busy_o,
    input  logic                   byte_valid_i,
    output logic                   byte_ready_o,
    input  logic [7:0]             byte_i,
    output logic                   wr_valid_o,
    input  logic                   wr_ready_i,
    output logic [31:0]            wr_word_o,
    output logic                   wr_ctrl_o,
    input  logic                   wm_hit_i,
    output logic                   wm_clr_o,
    output logic [CNT_W-1:0]       frames_o,
    output logic [CNT_W-1:0]       bytes_o,
    output logic [CNT_W-1:0]       drops_o
);

    localparam int MIN_WORDS = MIN_BYTES / 4;
    localparam longint HOLD_L = (longint'(CLK_HZ) * longint'(HOLD_NS)) / 64'd1_000_000_000;
    localparam int HOLD_CYC  = int'(HOLD_L);
    localparam int HIDX_W    = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;

    typedef struct packed {
        inj_state_e              st;
        logic [HIDX_W-1:0]       hidx;
        logic [LEN_W-1:0]        wcnt;
        logic [LEN_W-1:0]        len;
        logic [32*HDR_WORDS-1:0] hdr;
        logic                    busy;
        logic                    clr;
    } fr_t;

    fr_t q, d;

    logic        pk_load, pk_take, pk_valid, pk_last;
    logic [31:0] pk_word;
    logic        tmr_start, tmr_active, tmr_expire;
    logic        acc, rej;
    logic [1:0]  eof_vld;
    logic        wcnt_full;

    inj_byte_packer #(.LEN_W(LEN_W)) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (pk_load),
        .len_i        (req_len_i),
        .byte_valid_i (byte_valid_i),
        .byte_ready_o (byte_ready_o),
        .byte_i       (byte_i),
        .word_valid_o (pk_valid),
        .word_o       (pk_word),
        .last_o       (pk_last),
        .take_i       (pk_take)
    );

    inj_holdoff_timer #(.CYCLES(HOLD_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_start),
        .active_o (tmr_active),
        .expire_o (tmr_expire)
    );

    inj_tx_counters #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (acc),
        .rej_i    (rej),
        .len_i    (req_len_i),
        .frames_o (frames_o),
        .bytes_o  (bytes_o),
        .drops_o  (drops_o)
    );

    assign eof_vld   = (q.len < LEN_W'(MIN_BYTES)) ? 2'd0 : q.len[1:0];
    assign wcnt_full = ((q.wcnt + 1'b1) >= LEN_W'(MIN_WORDS));

    always_comb begin
        d           = q;
        d.busy      = 1'b0;
        d.clr       = 1'b0;
        req_ready_o = 1'b0;
        wr_valid_o  = 1'b0;
        wr_word_o   = '0;
        wr_ctrl_o   = 1'b0;
        pk_load     = 1'b0;
        pk_take     = 1'b0;
        tmr_start   = 1'b0;
        acc         = 1'b0;
        rej         = 1'b0;
        case (q.st)
            S_IDLE: begin
                req_ready_o = 1'b1;
                if (req_valid_i) begin
                    if (q_rdy_i) begin
                        acc     = 1'b1;
                        pk_load = 1'b1;
                        d.len   = req_len_i;
                        d.hdr   = req_hdr_i;
                        d.st    = S_SOF;
                    end else begin
                        rej    = 1'b1;
                        d.busy = 1'b1;
                    end
                end
            end
            S_SOF: begin
                wr_valid_o = 1'b1;
                wr_ctrl_o  = 1'b1;
                wr_word_o  = ctrl_word(1'b1, 1'b0, 2'd0);
                if (wr_ready_i) begin
                    d.hidx = '0;
                    d.st   = S_HDR;
                end
            end
            S_HDR: begin
                wr_valid_o = 1'b1;
                wr_word_o  = q.hdr[32*q.hidx +: 32];
                if (wr_ready_i) begin
                    if (q.hidx == HIDX_W'(HDR_WORDS - 1)) begin
                        d.wcnt = '0;
                        d.st   = (q.len == '0) ? S_PAD : S_DATA;
                    end else begin
                        d.hidx = q.hidx + 1'b1;
                    end
                end
            end
            S_DATA: begin
                wr_valid_o = pk_valid;
                wr_word_o  = pk_word;
                if (wr_ready_i && pk_valid) begin
                    pk_take = 1'b1;
                    d.wcnt  = q.wcnt + 1'b1;
                    if (pk_last) d.st = wcnt_full ? S_EOF : S_PAD;
                end
            end
            S_PAD: begin
                wr_valid_o = 1'b1;
                if (wr_ready_i) begin
                    d.wcnt = q.wcnt + 1'b1;
                    if (wcnt_full) d.st = S_EOF;
                end
            end
            S_EOF: begin
                wr_valid_o = 1'b1;
                wr_ctrl_o  = 1'b1;
                wr_word_o  = ctrl_word(1'b0, 1'b1, eof_vld);
                if (wr_ready_i) d.st = S_FCS;
            end
            S_FCS: begin
                wr_valid_o = 1'b1;
                if (wr_ready_i) begin
                    if (wm_hit_i) begin
                        tmr_start = 1'b1;
                        d.st      = S_HOLD;
                    end else begin
                        d.st = S_IDLE;
                    end
                end
            end
            S_HOLD: begin
                if (tmr_expire) begin
                    d.clr = wm_hit_i;
                    d.st  = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = q.busy;
    assign wm_clr_o = q.clr;

    AST_WRITE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_word_o) && $stable(wr_ctrl_o))); // R11

    AST_REJECT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !q_rdy_i) |=> (drops_o == $past(drops_o) + 1'b1)); // R1

    AST_HOLD_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_active |-> !req_ready_o); // R8

    AST_CLR_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        wm_clr_o |-> $past(tmr_expire)); // R9

    AST_PAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PAD && wr_valid_o) |-> (q.wcnt < LEN_W'(MIN_WORDS))); // R5

endmodule

// File: tb/test_inj_framer.sv
module test_inj_framer;

    localparam int HW    = 4;
    localparam int LW    = 14;
    localparam int CW    = 32;
    localparam int HOLD  = 6250;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [LW-1:0] req_len = '0;
    logic [32*HW-1:0] req_hdr = '0;
    logic          q_rdy = 1'b1;
    logic          busy;
    logic          byte_valid = 1'b0;
    logic          byte_ready;
    logic [7:0]    byte_d = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [31:0]   wr_word;
    logic          wr_ctrl;
    logic          wm_hit = 1'b0;
    logic          wm_clr;
    logic [CW-1:0] frames, nbytes, drops;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int fcs_cyc = 0;
    bit fcs_done = 0;
    bit running = 0;
    int ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int clr_cnt = 0;
    int exp_clr = 0;
    int exp_frames = 0, exp_bytes = 0, exp_drops = 0;
    bit prev_stall = 0;
    logic [32:0] prev_item;

    logic [33:0] exp_q[$];
    string       tag_q[$];

    inj_framer i_inj_framer (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_len_i(req_len), .req_hdr_i(req_hdr),
        .q_rdy_i(q_rdy), .busy_o(busy),
        .byte_valid_i(byte_valid), .byte_ready_o(byte_ready), .byte_i(byte_d),
        .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
        .wr_word_o(wr_word), .wr_ctrl_o(wr_ctrl),
        .wm_hit_i(wm_hit), .wm_clr_o(wm_clr),
        .frames_o(frames), .bytes_o(nbytes), .drops_o(drops)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: decide ready first, then a valid&&ready here is a handshake at the next edge
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (wm_clr) clr_cnt++;
            if (prev_stall) chk("R11 stalled write", {wr_valid, wr_ctrl, wr_word}, {1'b1, prev_item});
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
            prev_stall = wr_valid && !wr_ready;
            prev_item  = {wr_ctrl, wr_word};
            if (wr_valid && wr_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R1 unexpected write", {wr_ctrl, wr_word}, 64'h0);
                    checks--;
                    errors += (1 - 0) * 0;
                end else begin
                    logic [33:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, {wr_ctrl, wr_word}, e[32:0]);
                    if (e[33]) begin
                        fcs_done = 1;
                        fcs_cyc  = cyc;
                    end
                end
            end
        end
    end

    task automatic push(input logic last, input logic ctrl, input logic [31:0] w, input string t);
        exp_q.push_back({last, ctrl, w});
        tag_q.push_back(t);
    endtask

    task automatic send_frame(input int len, input int seed, input int wm_mode);
        int nwords;
        int gap;
        logic [31:0] w;
        logic [1:0] vld;
        logic [32*HW-1:0] hdr;
        wm_hit   = (wm_mode != 0);
        q_rdy    = 1'b1;
        fcs_done = 0;
        for (int k = 0; k < HW; k++) hdr[32*k +: 32] = 32'hA5000000 + 32'(seed * 16 + k);
        push(1'b0, 1'b1, 32'h11, "R2 start control");
        for (int k = 0; k < HW; k++) push(1'b0, 1'b0, hdr[32*k +: 32], "R3 header word");
        nwords = (len + 3) / 4;
        for (int wi = 0; wi < nwords; wi++) begin
            w = '0;
            for (int b = 0; b < 4; b++)
                if (wi * 4 + b < len) w[8*b +: 8] = 8'((wi * 4 + b) * 7 + seed);
            push(1'b0, 1'b0, w, "R4 data word");
        end
        for (int wi = nwords; wi < 15; wi++) push(1'b0, 1'b0, 32'h0, "R5 pad word");
        vld = (len < 60) ? 2'd0 : 2'(len % 4);
        push(1'b0, 1'b1, 32'h12 | (32'(vld) << 2), "R6 end control");
        push(1'b1, 1'b0, 32'h0, "R7 dummy fcs");

        @(negedge clk);
        req_valid = 1'b1;
        req_len   = LW'(len);
        req_hdr   = hdr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        exp_frames++;
        exp_bytes += len;
        chk("R10 frames count", 64'(frames), 64'(exp_frames));
        chk("R10 bytes count", 64'(nbytes), 64'(exp_bytes));
        for (int i = 0; i < len; i++) begin
            byte_valid = 1'b1;
            byte_d     = 8'(i * 7 + seed);
            while (!byte_ready) @(negedge clk);
            @(negedge clk);
        end
        byte_valid = 1'b0;
        gap = 0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            if (fcs_done && req_ready) break;
            if (fcs_done) gap++;
            if (wm_mode == 2 && gap == 100) wm_hit = 1'b0;
        end
        chk("R8 cycles until ready", 64'(cyc - fcs_cyc), 64'((wm_mode != 0) ? HOLD + 1 : 1));
        if (wm_mode == 1) exp_clr++;
        @(negedge clk);
        chk("R9 clear pulses", 64'(clr_cnt), 64'(exp_clr));
        chk("R7 scoreboard drained", 64'(exp_q.size()), 64'h0);
        wm_hit = 1'b0;
    endtask

    task automatic reject_req();
        q_rdy = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_len   = LW'(33);
        @(negedge clk);
        req_valid = 1'b0;
        exp_drops++;
        chk("R1 busy pulse", 64'(busy), 64'h1);
        chk("R1 drops count", 64'(drops), 64'(exp_drops));
        chk("R1 frames unchanged", 64'(frames), 64'(exp_frames));
        chk("R1 bytes unchanged", 64'(nbytes), 64'(exp_bytes));
        @(negedge clk);
        chk("R1 busy one cycle", 64'(busy), 64'h0);
        repeat (3) @(negedge clk);
        chk("R1 no write after reject", 64'(wr_valid), 64'h0);
        q_rdy = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset write idle", 64'(wr_valid), 64'h0);
        chk("R8 reset ready", 64'(req_ready), 64'h1);
        chk("R1 reset busy", 64'(busy), 64'h0);
        chk("R9 reset clear", 64'(wm_clr), 64'h0);
        chk("R10 reset counters", {frames, nbytes}, 64'h0);
        running = 1;

        ready_mode = 0;
        send_frame(1, 3, 0);
        send_frame(0, 5, 0);
        send_frame(59, 9, 0);
        send_frame(60, 11, 0);
        ready_mode = 1;
        send_frame(61, 13, 0);
        send_frame(63, 17, 0);
        send_frame(64, 19, 0);
        send_frame(101, 23, 0);
        send_frame(45, 29, 0);
        reject_req();
        send_frame(70, 31, 1);
        send_frame(62, 37, 2);
        ready_mode = 0;
        send_frame(4, 41, 1);
        reject_req();
        send_frame(8, 43, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule